// File: doc/BRIEF.md
# Nibble-Configurable I/O and Address Port

This block controls an 8-bit bidirectional port for a microcontroller. The port is split into two 4-bit halves. Each half either serves as general-purpose I/O or carries high-order external address bits. The lower half carries A11–A8 and the upper half carries A15–A12. Software sets the behaviour of each half by writing a small mode register. The same write interface also loads the output data register. The block drives a per-bit output enable and output value to the pads, and it samples the pad inputs into an input register that software can read.

For controlled byte transfers, the block runs a two-wire handshake on a data-valid line and a ready line, both active as described below. The direction of the upper half decides the direction of the transfer, and the lower half is forced to follow it. A strap input picks the reset state. In ROM mode both halves come up as inputs. In ROMless mode both halves come up as address outputs, and an extended-timing flag is raised for the bus controller. Software may clear that flag later. When the external bus is released, every half in address mode goes high-impedance.

Top module: `nibble_port`

## Requirements
- R1: After reset with `romless_strap`=0, the mode register is zero: `pad_oe`=0x00, `ext_timing`=0, `dav_oe`=0 and `rdy_oe`=0.
- R2: After reset with `romless_strap`=1, both halves are in address mode: `pad_oe`=0xFF, `pad_out`=`addr_hi`, and `ext_timing`=1.
- R3: A write with `wr_sel`=0 loads the mode register from `wr_data[5:0]`, one cycle later. The bits are: bit0 lower address mode, bit1 upper address mode, bit2 lower direction (1=output), bit3 upper direction, bit4 handshake enable, bit5 extended timing. `ext_timing` reflects bit5.
- R4: A half in address mode drives the matching bits of `addr_hi`, with its output enables at 1 while `bus_release`=0. The lower half can be in address mode while the upper half stays I/O.
- R5: While `bus_release`=1, every half in address mode has its output enables at 0. Halves in I/O mode are unaffected.
- R6: A half in I/O mode drives the matching bits of the data register (written with `wr_sel`=1), with its output enables equal to its direction bit.
- R7: Outside handshake-input mode, `in_data` equals `pad_in` as sampled at the previous clock edge.
- R8: With handshake enabled, the effective direction of the lower half equals the upper half's direction bit, whatever bit2 holds.
- R9: Handshake output mode (bit4=1, bit3=1) works as follows. `dav_oe`=1 and `rdy_oe`=0. A data write loads the register and drives `dav_out` low one cycle later. `dav_out` returns high after the synchronized `rdy_in` is seen high. A new transfer may start only once `rdy_in` has been seen low again.
- R10: In handshake output mode, data writes made while a transfer is in progress are ignored.
- R11: Handshake input mode (bit4=1, bit3=0) works as follows. `rdy_oe`=1 and `rdy_out` is high when the block can accept data. A falling edge on `dav_in` passes a two-flop synchronizer. On the third rising clock edge after the fall, `pad_in` is captured into `in_data` and `rdy_out` goes low. It stays low until an `rd_ack` pulse. Further falls that arrive while the value is held are ignored.
- R12: When a detected `dav_in` fall and `rd_ack` land in the same cycle while a value is held, the new byte is captured and `rdy_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| romless_strap | input | 1 | 1 selects ROMless reset state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = mode register, 1 = data register |
| wr_data | input | 8 | Write data |
| rd_ack | input | 1 | Software has read `in_data` |
| addr_hi | input | 8 | Address bits A15–A8 from the bus controller |
| bus_release | input | 1 | External bus released |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| in_data | output | 8 | Input register |
| dav_in | input | 1 | Data-valid pin input level |
| dav_out | output | 1 | Data-valid pin drive value (active low) |
| dav_oe | output | 1 | Data-valid pin output enable |
| rdy_in | input | 1 | Ready pin input level |
| rdy_out | output | 1 | Ready pin drive value |
| rdy_oe | output | 1 | Ready pin output enable |
| ext_timing | output | 1 | Extended bus timing request |

## Verification
In handshake-input mode, a detected data-valid fall can arrive in the very cycle software acknowledges the held byte. The bench holds a captured value and then lowers `dav_in` again. It times `rd_ack` so that it covers exactly the edge on which the synchronized fall is detected. Judging then checks that `in_data` takes the new pad value and that `rdy_out` stays low, rather than the byte being lost or ready being raised.

// File: rtl/nibble_port.sv
module nibble_port #(
  parameter int NIB = 4,
  localparam int W = 2 * NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         romless_strap,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ack,
  input  logic [W-1:0] addr_hi,
  input  logic         bus_release,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] in_data,
  input  logic         dav_in,
  output logic         dav_out,
  output logic         dav_oe,
  input  logic         rdy_in,
  output logic         rdy_out,
  output logic         rdy_oe,
  output logic         ext_timing
);
  typedef enum logic [1:0] {S_IDLE, S_ARM, S_VALID, S_REL} hs_st_e;

  logic [5:0]   mode_q;
  logic [W-1:0] out_q, in_q;
  logic [2:0]   dav_sh, rdy_sh;
  logic         hold_q;
  hs_st_e       st_q;

  wire lo_addr = mode_q[0];
  wire hi_addr = mode_q[1];
  wire hs_en   = mode_q[4];
  wire hi_dir  = mode_q[3];
  wire lo_dir  = hs_en ? hi_dir : mode_q[2];
  wire hs_out  = hs_en & hi_dir;
  wire hs_in   = hs_en & ~hi_dir;

  wire dav_fall = dav_sh[2] & ~dav_sh[1];
  wire rdy_s    = rdy_sh[1];
  wire data_wr  = wr_en & wr_sel;
  wire busy     = hs_out & (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mode_q <= romless_strap ? 6'b100011 : 6'b000000;
    else if (wr_en && !wr_sel) mode_q <= wr_data[5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                out_q <= '0;
    else if (data_wr && !busy) out_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_sh <= 3'b111;
      rdy_sh <= 3'b000;
    end else begin
      dav_sh <= {dav_sh[1:0], dav_in};
      rdy_sh <= {rdy_sh[1:0], rdy_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= S_IDLE;
    else if (!hs_out) st_q <= S_IDLE;
    else begin
      case (st_q)
        S_IDLE:  if (data_wr) st_q <= S_ARM;
        S_ARM:   st_q <= S_VALID;
        S_VALID: if (rdy_s) st_q <= S_REL;
        default: if (!rdy_s) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      hold_q <= 1'b0;
    end else if (!hs_in) begin
      in_q   <= pad_in;
      hold_q <= 1'b0;
    end else if (dav_fall && (!hold_q || rd_ack)) begin
      in_q   <= pad_in;
      hold_q <= 1'b1;
    end else if (rd_ack) begin
      hold_q <= 1'b0;
    end
  end

  assign pad_out[NIB-1:0] = lo_addr ? addr_hi[NIB-1:0] : out_q[NIB-1:0];
  assign pad_out[W-1:NIB] = hi_addr ? addr_hi[W-1:NIB] : out_q[W-1:NIB];
  assign pad_oe[NIB-1:0]  = {NIB{lo_addr ? ~bus_release : lo_dir}};
  assign pad_oe[W-1:NIB]  = {NIB{hi_addr ? ~bus_release : hi_dir}};

  assign in_data    = in_q;
  assign dav_oe     = hs_out;
  assign dav_out    = (st_q != S_VALID);
  assign rdy_oe     = hs_in;
  assign rdy_out    = hs_in & ~hold_q;
  assign ext_timing = mode_q[5];
endmodule

module nibble_port_chk #(
  parameter int NIB = 4,
  localparam int W = 2 * NIB
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_release,
  input logic [5:0]   mode_q,
  input logic [W-1:0] addr_hi,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] out_q,
  input logic         busy,
  input logic         data_wr,
  input logic         hold_q,
  input logic         hs_in,
  input logic         dav_fall,
  input logic         rd_ack,
  input logic         rdy_out,
  input logic         dav_oe,
  input logic         rdy_oe
);
  // R5
  br_addr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release && mode_q[0] |-> pad_oe[NIB-1:0] == '0);
  // R4
  addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_release && mode_q[1] |-> pad_oe[W-1:NIB] == '1 && pad_out[W-1:NIB] == addr_hi[W-1:NIB]);
  // R9
  pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dav_oe && rdy_oe));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_wr |=> $stable(out_q));
  // R11
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !rdy_out);
  // R12
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_in && dav_fall && rd_ack |=> hold_q);
endmodule

bind nibble_port nibble_port_chk #(.NIB(NIB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_release(bus_release), .mode_q(mode_q),
  .addr_hi(addr_hi), .pad_out(pad_out), .pad_oe(pad_oe), .out_q(out_q),
  .busy(busy), .data_wr(data_wr), .hold_q(hold_q), .hs_in(hs_in),
  .dav_fall(dav_fall), .rd_ack(rd_ack), .rdy_out(rdy_out),
  .dav_oe(dav_oe), .rdy_oe(rdy_oe)
);

// File: tb/tb_nibble_port.sv
module tb_nibble_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, romless_strap = 0;
  logic wr_en = 0, wr_sel = 0, rd_ack = 0, bus_release = 0;
  logic [7:0] wr_data = 0, addr_hi = 0, pad_in = 0;
  logic dav_in = 1, rdy_in = 0;
  logic [7:0] pad_out, pad_oe, in_data;
  logic dav_out, dav_oe, rdy_out, rdy_oe, ext_timing;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_port dut (
    .clk(clk), .rst_n(rst_n), .romless_strap(romless_strap), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_ack(rd_ack), .addr_hi(addr_hi),
    .bus_release(bus_release), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .in_data(in_data), .dav_in(dav_in), .dav_out(dav_out), .dav_oe(dav_oe),
    .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe), .ext_timing(ext_timing)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] exp_oe(input logic [5:0] m, input logic br);
    logic ld = m[4] ? m[3] : m[2];
    logic lo = m[0] ? ~br : ld;
    logic hi = m[1] ? ~br : m[3];
    return {{4{hi}}, {4{lo}}};
  endfunction

  function automatic logic [7:0] exp_out(input logic [5:0] m, input logic [7:0] d, input logic [7:0] a);
    return {m[1] ? a[7:4] : d[7:4], m[0] ? a[3:0] : d[3:0]};
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 0; romless_strap = strap;
    cycles(2);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    // R1 ROM reset
    do_reset(0);
    chk(pad_oe == 8'h00 && !ext_timing && !dav_oe && !rdy_oe, "R1", {pad_oe, 3'b0, ext_timing, dav_oe, rdy_oe}, 0);
    // R2 ROMless reset
    addr_hi = 8'hA5;
    do_reset(1);
    chk(pad_oe == 8'hFF && ext_timing, "R2 oe/ext", {pad_oe, 7'b0, ext_timing}, {8'hFF, 8'h01});
    chk(pad_out == 8'hA5, "R2 addr", pad_out, 8'hA5);
    // R5 bus release
    bus_release = 1; #1;
    chk(pad_oe == 8'h00, "R5 release", pad_oe, 8'h00);
    bus_release = 0;
    // R3 software clears extended timing
    wr(0, 8'h03);
    chk(!ext_timing, "R3 ext clear", ext_timing, 0);
    // R4 lower address, upper output GPIO
    wr(1, 8'h9C);
    wr(0, 8'h09);
    addr_hi = 8'h3E; #1;
    chk(pad_out == 8'h9E && pad_oe == 8'hFF, "R4 lower-only addr", {pad_out, pad_oe}, {8'h9E, 8'hFF});
    bus_release = 1; #1;
    chk(pad_oe == 8'hF0, "R5 gpio kept", pad_oe, 8'hF0);
    bus_release = 0;

    // R3 R4 R5 R6 R7 random modes
    for (int i = 0; i < 200; i++) begin
      logic [5:0] m = 6'($urandom);
      logic [7:0] d = 8'($urandom);
      logic [7:0] p = 8'($urandom);
      wr(0, 8'h00);
      wr(1, d);
      wr(0, {2'b00, m});
      addr_hi = 8'($urandom);
      bus_release = 1'($urandom);
      pad_in = p;
      @(negedge clk);
      chk(pad_oe == exp_oe(m, bus_release), "R6/R8 oe", pad_oe, exp_oe(m, bus_release));
      chk(pad_out == exp_out(m, d, addr_hi), "R4/R6 out", pad_out, exp_out(m, d, addr_hi));
      chk(ext_timing == m[5], "R3 ext", ext_timing, m[5]);
      if (!(m[4] && !m[3])) chk(in_data == p, "R7 sample", in_data, p);
    end
    bus_release = 0;

    // R8 R9 R10 output handshake
    wr(0, 8'h00);
    wr(0, 8'h18);
    chk(pad_oe == 8'hFF && dav_oe && !rdy_oe, "R8 forced out", {pad_oe, dav_oe, rdy_oe}, {8'hFF, 2'b10});
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 0;
    chk(dav_out == 1 && pad_out == 8'h5A, "R9 data before valid", {pad_out, 7'b0, dav_out}, {8'h5A, 8'h01});
    @(negedge clk);
    chk(dav_out == 0, "R9 valid low", dav_out, 0);
    wr(1, 8'hC3);
    chk(pad_out == 8'h5A, "R10 busy write", pad_out, 8'h5A);
    rdy_in = 1;
    cycles(4);
    chk(dav_out == 1, "R9 valid release", dav_out, 1);
    wr(1, 8'h11);
    chk(pad_out == 8'h5A && dav_out == 1, "R10 wait ready low", pad_out, 8'h5A);
    rdy_in = 0;
    cycles(4);
    wr(1, 8'h77);
    @(negedge clk);
    chk(pad_out == 8'h77 && dav_out == 0, "R9 next transfer", {pad_out, 7'b0, dav_out}, {8'h77, 8'h00});
    rdy_in = 1; cycles(4); rdy_in = 0; cycles(4);

    // R8 R11 input handshake
    wr(0, 8'h00);
    wr(0, 8'h14);
    chk(pad_oe == 8'h00 && rdy_oe && !dav_oe && rdy_out, "R8/R11 input mode", {pad_oe, rdy_oe, dav_oe, rdy_out}, {8'h00, 3'b101});
    pad_in = 8'hB6;
    @(negedge clk);
    dav_in = 0;
    cycles(2);
    chk(rdy_out == 1, "R11 sync delay", rdy_out, 1);
    @(negedge clk);
    chk(in_data == 8'hB6 && rdy_out == 0, "R11 capture", {in_data, 7'b0, rdy_out}, {8'hB6, 8'h00});
    pad_in = 8'h21;
    dav_in = 1; cycles(4); dav_in = 0; cycles(5);
    chk(in_data == 8'hB6 && rdy_out == 0, "R11 ignored while held", in_data, 8'hB6);
    dav_in = 1; cycles(4);
    // R12 fall and read in the same cycle
    pad_in = 8'h4D;
    dav_in = 0;
    cycles(2);
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    chk(in_data == 8'h4D && rdy_out == 0, "R12 capture wins", {in_data, 7'b0, rdy_out}, {8'h4D, 8'h00});
    dav_in = 1; cycles(3);
    rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk(rdy_out == 1 && in_data == 8'h4D, "R11 read releases", {in_data, 7'b0, rdy_out}, {8'h4D, 8'h01});

    done = 1;
    finish_run();
  end
endmodule